// File: doc/BRIEF.md
# Table-Driven State Machine with Patchable Microcode

This block is a general-purpose state-machine engine. It does not encode its next-state and output logic in gates. Each transition is a word read from a microcode table. The table address is the present state code with the input vector appended below it. Each word holds two fields: a next-state field in the upper bits and an output field in the lower bits. On every clock edge, one register takes the next state from the word that was read and a second register takes the output.

Most of the table sits in a fixed array whose contents are computed when the design is elaborated. A writable array is addressed with the same full table address. Any state whose code has its top bit set is served only from the writable array. Each state in the lower half also has a patch-enable bit. When that bit is set, the writable word at the same address replaces the fixed word. A chosen state, or a whole chain of states, can therefore be diverted into writable words without touching the fixed array. A patched fixed state can jump into the upper half, where any sequence can be placed.

A single write port loads words into the writable array. A separate strobe sets or clears patch-enable bits. Both kinds of write affect lookups from the next clock edge onward.

Top module: `ucode_fsm`

## Requirements
- R1: While `rst` is high at a rising edge, the state register is cleared to 0, `out_vec` is cleared to 0 and every patch-enable bit is cleared. The reset is synchronous and active high.
- R2: A table word is `SW+OW` bits wide. The next state sits in bits `[SW+OW-1:OW]` and the output in bits `[OW-1:0]`. The table address is `{state, in_vec}`, with the state in the upper `SW` bits.
- R3: At every rising edge without reset, both the state register and `out_vec` load from the word selected by the present state and the present `in_vec`. `out_vec` is therefore the output field of the word looked up in the previous cycle.
- R4: A state `s` below `2**(SW-1)` whose patch bit is clear follows the fixed table. The next state `n` is chosen as follows. If `in_vec[1]` is 1, `n` is 0; this takes priority. Otherwise, if `in_vec[0]` is 1, `n` is `(s+1) mod 2**(SW-1)`. Otherwise `n` is `s`. The output field is `(n+1) mod 2**OW`. Input bits above bit 1 are ignored.
- R5: A state whose top bit (`SW-1`) is set is always served from the writable array, at address `{state, in_vec}`.
- R6: When the patch bit of fixed state `s` is set (written through `pmap_state = s[SW-2:0]`), lookups from state `s` use the writable word at `{s, in_vec}` in place of the fixed word.
- R7: A word write or a patch-bit write at one edge is visible to the lookup at the next edge. A lookup at the same edge as the write uses the previous contents.
- R8: The fixed array never changes. Writes to the writable array or to the patch bits leave the transitions and outputs of unpatched fixed states unchanged.
- R9: Clearing a patch bit returns that state to its fixed-table behaviour from the next lookup onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_vec | input | IW | Input vector, the low part of the table address |
| out_vec | output | OW | Registered output field |
| wr_en | input | 1 | Write strobe for the writable array |
| wr_addr | input | SW+IW | Writable-array word address `{state, inputs}` |
| wr_data | input | SW+OW | Word to store, `{next_state, output}` |
| pmap_we | input | 1 | Write strobe for one patch-enable bit |
| pmap_state | input | SW-1 | Fixed state whose patch bit is written |
| pmap_on | input | 1 | New value of that patch bit |

## Verification
The hardest case to reach is the moment when a patch bit is set while the machine is sitting in that very state. The edge that carries the write must still use the fixed word, and only the following edge may take the diverted word. The stimulus first fills the whole writable array while the machine idles in state 0. It then steers the machine into a target fixed state and holds it there with an all-zero input. It sets the patch bit at that point, which moves the machine into the upper half. After that, a pseudo-random phase mixes input changes, word writes and patch toggles, and a behavioural model is compared against the output on every cycle.

// File: rtl/ucode_pkg.sv
package ucode_pkg;

  // Next state for a fixed-table state: bit 1 sends it home, bit 0 advances it.
  function automatic int fixed_next(int s, int i, int nfix);
    if ((i & 2) != 0)
      return 0;
    else if ((i & 1) != 0)
      return (s + 1) % nfix;
    else
      return s;
  endfunction

  // Output field for a fixed-table word: the next state plus one.
  function automatic int fixed_out(int n, int ow);
    return (n + 1) % (1 << ow);
  endfunction

endpackage

// File: rtl/ucode_rom.sv
module ucode_rom #(
  parameter int SW = 4,
  parameter int IW = 2,
  parameter int OW = 4
) (
  input  logic [SW+IW-2:0] addr,
  output logic [SW+OW-1:0] word
);
  localparam int WW    = SW + OW;
  localparam int NFIX  = 1 << (SW - 1);
  localparam int DEPTH = NFIX << IW;

  logic [WW-1:0] rom [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_word
    localparam int NX = ucode_pkg::fixed_next(a >> IW, a % (1 << IW), NFIX);
    localparam int OX = ucode_pkg::fixed_out(NX, OW);
    assign rom[a] = {SW'(NX), OW'(OX)};
  end

  assign word = rom[addr];
endmodule

// File: rtl/patch_ram.sv
module patch_ram #(
  parameter int AW = 6,
  parameter int WW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [WW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [WW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [WW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/patch_map.sv
module patch_map #(
  parameter int NB = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [$clog2(NB)-1:0] widx,
  input  logic                  wval,
  input  logic [$clog2(NB)-1:0] ridx,
  output logic                  hit,
  output logic [NB-1:0]         bits
);
  logic [NB-1:0] map_q;

  always_ff @(posedge clk) begin
    if (rst)     map_q       <= '0;
    else if (we) map_q[widx] <= wval;
  end

  assign hit  = map_q[ridx];
  assign bits = map_q;
endmodule

// File: rtl/word_select.sv
module word_select #(
  parameter int WW = 8
) (
  input  logic          upper_state,
  input  logic          patched,
  input  logic [WW-1:0] fixed_word,
  input  logic [WW-1:0] ram_word,
  output logic [WW-1:0] word
);
  always_comb begin
    if (upper_state || patched) word = ram_word;
    else                        word = fixed_word;
  end
endmodule

// File: rtl/ucode_fsm.sv
module ucode_fsm #(
  parameter int SW = 4,
  parameter int IW = 2,
  parameter int OW = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IW-1:0]    in_vec,
  output logic [OW-1:0]    out_vec,
  input  logic             wr_en,
  input  logic [SW+IW-1:0] wr_addr,
  input  logic [SW+OW-1:0] wr_data,
  input  logic             pmap_we,
  input  logic [SW-2:0]    pmap_state,
  input  logic             pmap_on
);
  localparam int AW   = SW + IW;
  localparam int WW   = SW + OW;
  localparam int NFIX = 1 << (SW - 1);

  logic [SW-1:0]   state_q;
  logic [AW-1:0]   addr;
  logic [WW-1:0]   rom_word;
  logic [WW-1:0]   ram_word;
  logic [WW-1:0]   word;
  logic            map_hit;
  logic [NFIX-1:0] pmap_bits;

  assign addr = {state_q, in_vec};

  ucode_rom #(.SW(SW), .IW(IW), .OW(OW)) u_rom (
    .addr (addr[AW-2:0]),
    .word (rom_word)
  );

  patch_ram #(.AW(AW), .WW(WW)) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (addr),
    .rdata (ram_word)
  );

  patch_map #(.NB(NFIX)) u_map (
    .clk  (clk),
    .rst  (rst),
    .we   (pmap_we),
    .widx (pmap_state),
    .wval (pmap_on),
    .ridx (state_q[SW-2:0]),
    .hit  (map_hit),
    .bits (pmap_bits)
  );

  word_select #(.WW(WW)) u_sel (
    .upper_state (state_q[SW-1]),
    .patched     (map_hit),
    .fixed_word  (rom_word),
    .ram_word    (ram_word),
    .word        (word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= '0;
      out_vec <= '0;
    end else begin
      state_q <= word[WW-1:OW];
      out_vec <= word[OW-1:0];
    end
  end
endmodule

// File: rtl/ucode_fsm_chk.sv
module ucode_fsm_chk #(
  parameter int SW = 4,
  parameter int IW = 2,
  parameter int OW = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic [IW-1:0]         in_vec,
  input logic [OW-1:0]         out_vec,
  input logic                  wr_en,
  input logic [SW+IW-1:0]      wr_addr,
  input logic [SW+OW-1:0]      wr_data,
  input logic [SW-1:0]         state_q,
  input logic [(1<<(SW-1))-1:0] map_q
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (state_q == '0 && out_vec == '0 && map_q == '0)); // R1

  AST_FIXED_HOME: assert property (@(posedge clk) disable iff (rst)
    (!state_q[SW-1] && !map_q[state_q[SW-2:0]] && in_vec[1]) |=> (state_q == '0 && out_vec == OW'(1))); // R4

  AST_FIXED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!state_q[SW-1] && !map_q[state_q[SW-2:0]] && in_vec[1:0] == 2'b00)
      |=> ($stable(state_q) && out_vec == OW'(state_q + 1'b1))); // R4

  AST_UPPER_FRESH_WORD: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en) && state_q[SW-1] && {state_q, in_vec} == $past(wr_addr))
      |=> ({state_q, out_vec} == $past(wr_data, 2))); // R5

  AST_PATCHED_FRESH_WORD: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en) && !state_q[SW-1] && map_q[state_q[SW-2:0]] && {state_q, in_vec} == $past(wr_addr))
      |=> ({state_q, out_vec} == $past(wr_data, 2))); // R6
endmodule

bind ucode_fsm ucode_fsm_chk #(.SW(SW), .IW(IW), .OW(OW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .in_vec  (in_vec),
  .out_vec (out_vec),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .state_q (state_q),
  .map_q   (pmap_bits)
);

// File: tb/sim_ucode_fsm.sv
`timescale 1ns/1ps
module sim_ucode_fsm;
  localparam int SW = 4, IW = 2, OW = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] in_v = '0;
  logic [3:0] out_vec;
  logic       wr_en = 1'b0;
  logic [5:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       pm_we = 1'b0;
  logic [2:0] pm_st = '0;
  logic       pm_on = 1'b0;

  int    n_chk = 0, n_fail = 0;
  bit    done = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  ucode_fsm #(.SW(SW), .IW(IW), .OW(OW)) u0 (
    .clk(clk), .rst(rst), .in_vec(in_v), .out_vec(out_vec),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pmap_we(pm_we), .pmap_state(pm_st), .pmap_on(pm_on)
  );

  // Behavioural reference model.
  int ram_m [64];
  bit map_m [8];
  int st_m = 0, out_m = 0;

  always @(posedge clk) begin
    int a, w, n;
    if (rst) begin
      st_m = 0; out_m = 0;
      foreach (map_m[k]) map_m[k] = 0;
    end else begin
      a = st_m * 4 + int'(in_v);
      if (st_m >= 8 || map_m[st_m]) w = ram_m[a];
      else begin
        if (in_v[1])      n = 0;
        else if (in_v[0]) n = (st_m + 1) % 8;
        else              n = st_m;
        w = n * 16 + (n + 1) % 16;
      end
      st_m = w / 16; out_m = w % 16;
      if (pm_we) map_m[pm_st] = pm_on;
    end
    if (wr_en) ram_m[wr_addr] = int'(wr_data);
  end

  task automatic cyc();
    @(negedge clk);
    n_chk++;
    if (out_vec !== 4'(out_m)) begin
      n_fail++;
      $display("FAIL %s: out_vec=%0h expected=%0h at %0t", tag, out_vec, out_m, $time);
    end
  endtask

  task automatic run(input logic [1:0] v, input int n);
    in_v = v;
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    logic [15:0] lf;
    lf = 16'hACE1;
    // R1: reset state
    tag = "R1";
    run(2'b00, 3);
    rst = 1'b0;
    // R8: fill the writable array while idling in state 0
    tag = "R8";
    for (int a = 0; a < 64; a++) begin
      wr_en = 1'b1; wr_addr = 6'(a);
      wr_data = {4'((a * 5 + 3) % 16), 4'(a) ^ 4'hA};
      cyc();
    end
    wr_en = 1'b0;
    cyc();
    // R4: fixed table walk, hold, home, priority of home, wrap
    tag = "R4";
    run(2'b01, 12); run(2'b00, 3); run(2'b10, 2); run(2'b01, 5); run(2'b11, 2);
    // R7: set the patch bit while sitting in state 3
    run(2'b01, 3);
    run(2'b00, 2);
    tag = "R7";
    pm_we = 1'b1; pm_st = 3'd3; pm_on = 1'b1;
    cyc();
    pm_we = 1'b0;
    cyc();
    // R5 R2: walk through the upper half and back
    tag = "R5 R2";
    run(2'b00, 3); run(2'b01, 4); run(2'b11, 3); run(2'b10, 4);
    // R6: drive into the patched state again
    tag = "R6";
    rst = 1'b1; cyc(); rst = 1'b0;
    pm_we = 1'b1; pm_st = 3'd2; pm_on = 1'b1; in_v = 2'b01;
    cyc(); pm_we = 1'b0;
    run(2'b01, 4); run(2'b00, 3);
    // R9: clear the patch bits, fixed behaviour returns
    tag = "R9";
    pm_we = 1'b1; pm_st = 3'd2; pm_on = 1'b0; in_v = 2'b10;
    cyc();
    pm_st = 3'd3; cyc();
    pm_we = 1'b0;
    run(2'b10, 2); run(2'b01, 10); run(2'b00, 2);
    // R3: pseudo-random mix of inputs, writes and patch toggles
    tag = "R3";
    for (int i = 0; i < 400; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      in_v    = lf[1:0];
      wr_en   = (lf[5:3] == 3'b101);
      wr_addr = lf[11:6];
      wr_data = lf[15:8] ^ lf[7:0];
      pm_we   = (lf[14:12] == 3'b011);
      pm_st   = lf[9:7];
      pm_on   = lf[2];
      if (i % 97 == 50) begin rst = 1'b1; tag = "R1"; end
      else begin rst = 1'b0; tag = "R3"; end
      cyc();
    end
    wr_en = 1'b0; pm_we = 1'b0; rst = 1'b0;
    cyc();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule